// File: doc/BRIEF.md
# Cascaded Square-Wave Interval Timer

This block makes a square wave whose half-period is set by software. Two 8-bit counter stages are chained so that they act as one 16-bit interval counter. The low stage carries into the high stage. The 16-bit compare value is written one byte at a time into two compare registers.

A power-of-two prescaler turns the system clock into a count tick. When the counter equals the compare value on a tick, three things happen at once: the counter clears to zero, the square-wave level inverts, and a match pulse lasting one system-clock cycle is issued. A slow-mode setting halves the tick rate, which doubles every period. An enable bit decides whether the square-wave level is driven onto the output pin.

Software configures the block through a plain write strobe with a small address. The timer is started and stopped by a run bit in the control register.

Top module: `sqw_cascade_timer`

## Requirements
- R1: After the synchronous active-low reset, `sq_out` and `match_pulse` are 0, counting is stopped and output enable is 0. No match pulse appears until the run bit is written to 1.
- R2: Address 0 holds the low compare byte and address 1 the high compare byte. A match needs both counter stages to equal their compare bytes on the same tick, so a compare value of 0x0100 or 0x01FF runs for its full 16-bit length.
- R3: With compare value N and a count tick every D system cycles, consecutive match pulses are (N+1)·D cycles apart.
- R4: Control register (address 2) bits [3:0] select the prescaler in fast mode. Codes 0 to 8 give D = 2^(code+1), code 9 gives D = 2^11, and codes 10 to 15 give D = 2^12.
- R5: Control bit 5 selects fast mode when 1. When it is 0, D doubles for every code.
- R6: Each match inverts the internal square-wave level and raises `match_pulse` for exactly one cycle on the same clock edge.
- R7: Control bit 4 is the output enable. While it is 0, `sq_out` is held low, but matches and level inversions continue.
- R8: A compare write made while running takes effect only at the next counter clear. A write that lands on the clearing edge itself waits one more period.
- R9: Control bit 6 is the run bit. Writing it to 0 stops the ticks and clears the counter. Writing it to 1 again gives a first match exactly (N+1)·D cycles after the write edge.
- R10: A compare value of 0 produces a match on every tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 low compare byte, 1 high compare byte, 2 control |
| wr_data | input | 8 | Write data |
| sq_out | output | 1 | Square-wave output, gated by the enable bit |
| match_pulse | output | 1 | One-cycle pulse on every compare match |

## Verification
Two functions can fall on the same edge: a software compare write, and the counter clear that reloads the active compare value. The bench starts the timer from a known edge, computes the clearing edge, and times a write of the low byte to land exactly there. It then checks the next two pulse spacings: the first must keep the old length and the second must take the new one. A behavioural reference model is compared on every cycle throughout, so a stop written while a tick is due is judged the same way.

// File: rtl/sqw_pkg.sv
// Package: shared control-field layout and prescaler decode for the
// cascaded square-wave timer. Assumes fast-mode codes above 9 saturate.
package sqw_pkg;

    localparam int PSEL_W        = 4;
    localparam int CTRL_OE_BIT   = 4;
    localparam int CTRL_FAST_BIT = 5;
    localparam int CTRL_RUN_BIT  = 6;
    localparam int SHIFT_W       = 4;

    typedef struct packed {
        logic              run;
        logic              fast;
        logic              oe;
        logic [PSEL_W-1:0] psel;
    } ctrl_t;

    // Returns log2 of the tick divider for a select code and clock mode.
    function automatic logic [SHIFT_W-1:0] psel_to_shift(
        input logic [PSEL_W-1:0] psel,
        input logic              fast
    );
        logic [SHIFT_W-1:0] e;
        if (psel <= 4'd8)       e = psel + 4'd1;
        else if (psel == 4'd9)  e = 4'd11;
        else                    e = 4'd12;
        return fast ? e : e + 4'd1;
    endfunction

endpackage

// File: rtl/sqw_prescaler.sv
// Prescaler: emits a one-cycle tick every 2^shift system cycles while run
// is high. Assumes shift >= 1, so ticks are never back to back. The
// counter is held at zero while stopped, so a restart is deterministic.
module sqw_prescaler
    import sqw_pkg::*;
#(
    parameter int PRE_W = 14
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  run,
    input  logic [PSEL_W-1:0]     psel,
    input  logic                  fast,
    output logic                  tick
);

    logic [PRE_W-1:0]   cnt;
    logic [PRE_W-1:0]   div_m1;
    logic [SHIFT_W-1:0] shift;

    // Decode the select code and mode into a terminal count.
    always_comb begin
        shift  = psel_to_shift(psel, fast);
        div_m1 = ({{(PRE_W-1){1'b0}}, 1'b1} << shift) - 1'b1;
        tick   = run && (cnt >= div_m1);
    end

    // Divider counter: restarts on each tick, held clear while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt <= '0;
        else if (!run || tick)  cnt <= '0;
        else                    cnt <= cnt + 1'b1;
    end

    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R3

    AST_NO_TICK_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !tick); // R9

endmodule

// File: rtl/sqw_byte_stage.sv
// One counter stage: clears or increments, and reports a carry when it
// increments from all ones. Assumes clear has priority over increment.
module sqw_byte_stage #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] val,
    output logic         carry
);

    // Carry out when this stage wraps on an increment.
    always_comb carry = inc && (&val);

    // Stage register update.
    always_ff @(posedge clk) begin
        if (!rst_n)     val <= '0;
        else if (clr)   val <= '0;
        else if (inc)   val <= val + 1'b1;
    end

endmodule

// File: rtl/sqw_cascade_counter.sv
// Cascaded interval counter: STAGES byte stages chained by carry. It
// advances on a tick without a match and clears on a matching tick or
// while stopped. Assumes the counter never passes the active compare.
module sqw_cascade_counter #(
    parameter int STAGE_W = 8,
    parameter int STAGES  = 2,
    localparam int CNT_W  = STAGE_W * STAGES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             hit,
    output logic [CNT_W-1:0] count
);

    logic [STAGES:0] chain;
    logic            clr;

    // Entry of the carry chain and the shared clear.
    always_comb begin
        chain[0] = tick && !hit;
        clr      = !run || (tick && hit);
    end

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        sqw_byte_stage #(.W(STAGE_W)) u_stage (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr),
            .inc   (chain[g]),
            .val   (count[g*STAGE_W +: STAGE_W]),
            .carry (chain[g+1])
        );
    end

    AST_NO_FULL_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !chain[STAGES]); // R3

    AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (count == '0)); // R9

    if (STAGES > 1) begin : g_carry_chk
        AST_UPPER_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
            (count[CNT_W-1:STAGE_W] != $past(count[CNT_W-1:STAGE_W]))
            |-> (count[STAGE_W-1:0] == '0)); // R2
    end

endmodule

// File: rtl/sqw_match_unit.sv
// Compare and toggle: holds the active compare value, which is reloaded
// from the software copy at each clear or while stopped. It detects a
// match stage by stage and produces the match pulse and the wave level.
module sqw_match_unit #(
    parameter int STAGE_W = 8,
    parameter int STAGES  = 2,
    localparam int CNT_W  = STAGE_W * STAGES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] cmp_shadow,
    output logic             hit,
    output logic             pulse,
    output logic             level
);

    logic [CNT_W-1:0]  act;
    logic [STAGES-1:0] eq;

    for (genvar g = 0; g < STAGES; g++) begin : g_eq
        // Per-stage byte equality.
        always_comb eq[g] = (count[g*STAGE_W +: STAGE_W] == act[g*STAGE_W +: STAGE_W]);
    end

    // Match only when every stage agrees at once.
    always_comb hit = &eq;

    // Active compare reload at clear, or continuously while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n)                     act <= '0;
        else if (!run || (tick && hit)) act <= cmp_shadow;
    end

    // One-cycle match pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) pulse <= 1'b0;
        else        pulse <= tick && hit;
    end

    // Square-wave level inverts on each match.
    always_ff @(posedge clk) begin
        if (!rst_n)             level <= 1'b0;
        else if (tick && hit)   level <= ~level;
    end

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse); // R6

    AST_TOGGLE_WITH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> (level != $past(level))); // R6

    AST_CLEAR_AFTER_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> (count == '0)); // R3

endmodule

// File: rtl/sqw_cascade_timer.sv
// Top: register file (compare bytes and control) plus prescaler, cascaded
// counter and match unit. Assumes STAGE_W >= 7 so that control fits in one
// data word, and that the control address follows the compare bytes.
module sqw_cascade_timer
    import sqw_pkg::*;
#(
    parameter int STAGE_W = 8,
    parameter int STAGES  = 2,
    parameter int ADDR_W  = 2,
    parameter int PRE_W   = 14
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [STAGE_W-1:0] wr_data,
    output logic               sq_out,
    output logic               match_pulse
);

    localparam int CNT_W = STAGE_W * STAGES;
    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(STAGES);

    logic [CNT_W-1:0] cmp_shadow;
    logic [CNT_W-1:0] count;
    ctrl_t            ctrl;
    logic             tick;
    logic             hit;
    logic             level;
    logic             wr_unused;

    // Bits of the data word the control register does not use.
    always_comb wr_unused = &{1'b0, wr_data[STAGE_W-1:CTRL_RUN_BIT+1]};

    for (genvar g = 0; g < STAGES; g++) begin : g_cmp
        // Software copy of one compare byte.
        always_ff @(posedge clk) begin
            if (!rst_n)
                cmp_shadow[g*STAGE_W +: STAGE_W] <= '0;
            else if (wr_en && wr_addr == ADDR_W'(g))
                cmp_shadow[g*STAGE_W +: STAGE_W] <= wr_data;
        end
    end

    // Control register: select code, enable, mode and run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (wr_en && wr_addr == CTRL_ADDR) begin
            ctrl.psel <= wr_data[PSEL_W-1:0];
            ctrl.oe   <= wr_data[CTRL_OE_BIT];
            ctrl.fast <= wr_data[CTRL_FAST_BIT];
            ctrl.run  <= wr_data[CTRL_RUN_BIT];
        end
    end

    sqw_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (ctrl.run),
        .psel  (ctrl.psel),
        .fast  (ctrl.fast),
        .tick  (tick)
    );

    sqw_cascade_counter #(.STAGE_W(STAGE_W), .STAGES(STAGES)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (ctrl.run),
        .tick  (tick),
        .hit   (hit),
        .count (count)
    );

    sqw_match_unit #(.STAGE_W(STAGE_W), .STAGES(STAGES)) u_match (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (ctrl.run),
        .tick       (tick),
        .count      (count),
        .cmp_shadow (cmp_shadow),
        .hit        (hit),
        .pulse      (match_pulse),
        .level      (level)
    );

    // Pin gating by the output enable.
    always_comb sq_out = level & ctrl.oe;

    AST_PIN_FOLLOWS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (match_pulse && ctrl.oe && $past(ctrl.oe)) |-> (sq_out != $past(sq_out))); // R6

    AST_PIN_QUIET_NO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (!match_pulse && ctrl.oe && $past(ctrl.oe)) |-> $stable(sq_out)); // R7

endmodule

// File: tb/sqw_cascade_timer_tb.sv
// Bench: behavioural per-cycle reference model plus targeted period checks.
module sqw_cascade_timer_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    wire        sq_out;
    wire        match_pulse;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int last_start = 0;
    int pulse_t[$];
    bit mon_on = 1'b0;

    // reference model state
    int m_ph, m_ticks, m_act, m_sh, m_psel;
    bit m_run, m_fast, m_oe, m_q, m_pulse;

    sqw_cascade_timer dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .sq_out      (sq_out),
        .match_pulse (match_pulse)
    );

    always #5 clk = ~clk;

    function automatic int div_of(int psel, bit fast);
        int e;
        e = (psel <= 8) ? psel + 1 : (psel == 9) ? 11 : 12;
        return (1 << e) * (fast ? 1 : 2);
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // reference model, advanced on every edge
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_ph = 0; m_ticks = 0; m_act = 0; m_sh = 0; m_psel = 0;
            m_run = 0; m_fast = 0; m_oe = 0; m_q = 0; m_pulse = 0;
        end else begin
            if (!m_run) begin
                m_ph = 0; m_ticks = 0; m_pulse = 0; m_act = m_sh;
            end else if (m_ph >= div_of(m_psel, m_fast) - 1) begin
                m_ph = 0;
                if (m_ticks == m_act) begin
                    m_ticks = 0; m_pulse = 1; m_q = !m_q; m_act = m_sh;
                end else begin
                    m_ticks++; m_pulse = 0;
                end
            end else begin
                m_ph++; m_pulse = 0;
            end
            if (wr_en) begin
                case (wr_addr)
                    2'd0: m_sh = (m_sh & 32'hFF00) | int'(wr_data);
                    2'd1: m_sh = (m_sh & 32'h00FF) | (int'(wr_data) << 8);
                    2'd2: begin
                        m_psel = int'(wr_data[3:0]); m_oe = wr_data[4];
                        m_fast = wr_data[5];          m_run = wr_data[6];
                    end
                    default: ;
                endcase
            end
        end
    end

    // per-cycle comparison and pulse time log
    always @(negedge clk) begin
        if (mon_on) begin
            chk("R6 match_pulse vs model", int'(match_pulse), int'(m_pulse));
            chk("R7 sq_out vs model", int'(sq_out), int'(m_q & m_oe));
            if (match_pulse) pulse_t.push_back(cyc);
        end
    end

    task automatic wr(int addr, int data);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 2'(addr); wr_data = 8'(data);
        last_start = cyc + 1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic cfg(int psel, bit fast, bit oe, int n);
        wr(2, 0);
        wr(0, n & 255);
        wr(1, (n >> 8) & 255);
        wr(2, 64 | (int'(fast) << 5) | (int'(oe) << 4) | psel);
    endtask

    task automatic measure(string req, int exp);
        int n0;
        n0 = pulse_t.size();
        while (pulse_t.size() < n0 + 2) @(negedge clk);
        chk(req, pulse_t[n0+1] - pulse_t[n0], exp);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        finish_run();
    end

    initial begin
        int n0;
        repeat (4) @(negedge clk);
        chk("R1 sq_out in reset", int'(sq_out), 0);
        chk("R1 match_pulse in reset", int'(match_pulse), 0);
        rst_n = 1'b1;
        mon_on = 1'b1;
        repeat (40) @(negedge clk);
        chk("R1 no pulse while stopped", pulse_t.size(), 0);

        cfg(0, 1, 1, 3);   measure("R3 N=3 D=2", 8);
        cfg(4, 1, 1, 5);   measure("R4 code4 fast N=5", 192);
        cfg(0, 0, 1, 9);   measure("R5 code0 slow N=9", 40);
        cfg(9, 1, 1, 1);   measure("R4 code9 fast N=1", 4096);
        cfg(15, 1, 1, 0);  measure("R4 code15 fast N=0", 4096);
        cfg(10, 0, 1, 0);  measure("R5 code10 slow N=0", 8192);
        cfg(1, 1, 1, 0);   measure("R10 N=0 every tick D=4", 4);
        cfg(0, 1, 1, 'h0100); measure("R2 cmp 0x0100", 514);
        cfg(0, 1, 1, 'h01FF); measure("R2 cmp 0x01FF", 1024);

        // R7: output held low while disabled, matching continues
        cfg(0, 1, 0, 2);
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            chk("R7 pin low while disabled", int'(sq_out), 0);
        end
        measure("R7 matches continue while disabled", 6);
        wr(2, 64 | 32 | 16);

        // R8: mid-period compare write waits for the next clear
        cfg(0, 1, 1, 9);
        n0 = pulse_t.size();
        while (pulse_t.size() < n0 + 1) @(negedge clk);
        repeat (3) @(negedge clk);
        wr(0, 3);
        while (pulse_t.size() < n0 + 3) @(negedge clk);
        chk("R8 period after write keeps old value", pulse_t[n0+1] - pulse_t[n0], 20);
        chk("R8 new value after clear", pulse_t[n0+2] - pulse_t[n0+1], 8);

        // R8: write landing on the clearing edge itself
        cfg(0, 1, 1, 4);
        n0 = pulse_t.size();
        while (cyc != last_start + 10 - 1) @(negedge clk);
        wr_en = 1'b1; wr_addr = 2'd0; wr_data = 8'd1;
        @(negedge clk);
        wr_en = 1'b0;
        while (pulse_t.size() < n0 + 3) @(negedge clk);
        chk("R8 first clear at start+10", pulse_t[n0] - last_start, 10);
        chk("R8 same-edge write not yet active", pulse_t[n0+1] - pulse_t[n0], 10);
        chk("R8 same-edge write active next", pulse_t[n0+2] - pulse_t[n0+1], 4);

        // R9: stop halts matches, restart latency is exact
        wr(2, 32 | 16);
        n0 = pulse_t.size();
        repeat (60) @(negedge clk);
        chk("R9 no pulse after stop", pulse_t.size(), n0);
        cfg(0, 1, 1, 4);
        n0 = pulse_t.size();
        while (pulse_t.size() < n0 + 1) @(negedge clk);
        chk("R9 first pulse latency after restart", pulse_t[n0] - last_start, 10);

        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule